// File: doc/BRIEF.md
# AAL5 Multi-Connection Segmentation Engine

This block turns user packets into ATM cells, using the AAL type 5 common part. The user delivers words of 32 bits in bursts. Each burst is tagged with a 4-bit connection number. A burst holds a whole number of 48-byte cell payloads, or it ends the packet with an end flag. The block gathers one 48-byte payload at a time into a cell buffer. It then sends the cell as 13 output words: one header word followed by 12 payload words. The header carries the path and channel identifiers of the connection, which are taken from a small table that a host can write. The fifth header octet (HEC) is added by the downstream cell layer.

The running byte count and running CRC-32 of each connection are written back to a per-connection store after every cell. Cells from different connections may therefore interleave at any cell boundary. At the end of a packet the block adds zero pad and an 8-byte trailer. The trailer holds the user-to-user octet, the common part indicator, the length and the CRC. When the final data leaves fewer than 8 free bytes in the cell, the trailer moves into one extra cell that is all pad apart from the trailer. An abort closes the packet that is open on a connection.

Top module: `aal5SegEngine`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1. Every connection starts a new packet with CRC all ones and length 0.
- R2: Each cell is 13 output words. Word 0 is the header and is the only word with `outSoc` high. The header bits, from MSB to LSB, are: 4 zero bits, 8-bit VPI, 16-bit VCI, a zero bit, the congestion bit, the last-cell bit and the CLP bit. Payload bytes follow in arrival order, with the first byte in bits 31:24 of each word.
- R3: The VPI and VCI in a header are the values last written for that connection through `cfgWe`/`cfgConn`/`cfgVpi`/`cfgVci`.
- R4: The running CRC and length of a packet are kept per connection across cells. Whole cells of different connections may interleave without corrupting one another's trailers.
- R5: A transfer with `inEop` high ends the packet. `inBytes` gives the number of valid bytes in that word, with 0 meaning 4; the unused bytes are replaced by zero. When the data of the last cell fits in 40 bytes, zero pad fills bytes up to 40. Bytes 40 to 47 are then UU, CPI, length (2 bytes, data bytes only, MSB first) and CRC (4 bytes). Packets of up to 32768 bytes are supported.
- R6: When the data of the last cell occupies more than 40 bytes, the rest of that cell is zero pad. One extra cell follows, holding 40 zero bytes and the trailer.
- R7: The CRC is MSB first with polynomial 0x04C11DB7 and starts at all ones. It covers all data, all pad and the first 4 trailer bytes, and the trailer carries its complement.
- R8: The last-cell bit is 1 only in the final cell of a packet. CLP, congestion, UU and CPI are taken from the last transfer accepted before that cell is complete.
- R9: A transfer with `inAbort` high carries no data. It ends the open packet on its connection at the current word position. The final cell then has a length field of 0, and the CRC continues over whatever data was accepted. The pad and extra-cell rules of R5 and R6 apply.
- R10: While a cell waits with `outReady` low, `outValid` stays high and `outData` holds its value. No input is accepted while a cell is being sent.
- R11: After the final cell of a packet, the connection's state returns to the value given in R1, so the next packet on it starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input transfer valid |
| inReady | output | 1 | Engine accepts an input transfer |
| inData | input | 32 | Four payload bytes, first byte in bits 31:24 |
| inConn | input | 4 | Connection number of the burst |
| inEop | input | 1 | Last word of the packet |
| inBytes | input | 2 | Valid bytes in the last word (0 means 4) |
| inAbort | input | 1 | Abort the open packet; data is ignored |
| inUu | input | 8 | User-to-user octet for the trailer |
| inCpi | input | 8 | Common part indicator for the trailer |
| inClp | input | 1 | Cell loss priority bit for the header |
| inCi | input | 1 | Congestion bit for the header |
| cfgWe | input | 1 | Write strobe for the identifier table |
| cfgConn | input | 4 | Table entry to write |
| cfgVpi | input | 8 | VPI value to write |
| cfgVci | input | 16 | VCI value to write |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Downstream accepts the output word |
| outData | output | 32 | Cell word |
| outSoc | output | 1 | Marks the header word of a cell |

## Verification
On every cycle the assertions check the output handshake (a stalled word holds its value), the 13-word cell spacing of `outSoc`, the block's refusal of input while a cell is being sent, the pause in input after an end or abort, and the zero length field in abort cells. Cell contents can only be shown by the bench's scenarios. These include the CRC and length in each trailer, the choice between one last cell and an extra cell, and the separation of per-connection state under interleaving. The bench computes these byte by byte from an independent model. It sweeps every packet length from 1 to 100 bytes over all connections and adds interleaved, aborted and maximum-length packets.

// File: rtl/aal5SegPkg.sv
package aal5SegPkg;
  localparam int CELL_WORDS = 12;
  localparam int IDX_W = 4;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

  typedef struct packed {
    logic             latchAttr;
    logic             firstWord;
    logic             takeWord;
    logic             padWrite;
    logic [1:0]       padSel;     // 0 zero pad, 1 uu/cpi/len, 2 crc
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
    logic             saveState;
    logic             clearState;
    logic             zeroLen;
  } segStrobes_t;

  function automatic logic [31:0] crc32Word(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else r = {r[30:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/aal5SegCtrl.sv
module aal5SegCtrl
  import aal5SegPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inEop,
  input  logic        inAbort,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output logic        outSoc,
  output segStrobes_t stb
);
  typedef enum logic [1:0] {S_ACC, S_PAD, S_SEND} segState_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);
  localparam logic [IDX_W-1:0] LEN_IDX  = IDX_W'(CELL_WORDS - 2);
  localparam logic [IDX_W-1:0] SEND_END = IDX_W'(CELL_WORDS);

  segState_e        state;
  logic [IDX_W-1:0] wIdx;
  logic [IDX_W-1:0] sIdx;
  logic             endPend;
  logic             fits;
  logic             abortMode;
  logic [IDX_W-1:0] padStart;
  logic             trailerHere;

  assign padStart    = inAbort ? wIdx : wIdx + 1'b1;
  assign trailerHere = endPend && fits;

  always_comb begin
    stb        = '0;
    inReady    = (state == S_ACC);
    outValid   = (state == S_SEND);
    outSoc     = outValid && (sIdx == '0);
    stb.rdIdx  = sIdx;
    stb.wrIdx  = wIdx;
    stb.zeroLen = abortMode;
    case (state)
      S_ACC: if (inValid) begin
        stb.latchAttr = 1'b1;
        stb.firstWord = (wIdx == '0);
        stb.takeWord  = !inAbort;
        stb.saveState = !inAbort && (wIdx == LAST_IDX);
      end
      S_PAD: begin
        stb.padWrite = 1'b1;
        if (trailerHere && wIdx == LEN_IDX) stb.padSel = 2'd1;
        if (trailerHere && wIdx == LAST_IDX) stb.padSel = 2'd2;
        stb.saveState  = (wIdx == LAST_IDX) && !trailerHere;
        stb.clearState = (wIdx == LAST_IDX) && trailerHere;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_ACC;
      wIdx      <= '0;
      sIdx      <= '0;
      endPend   <= 1'b0;
      fits      <= 1'b0;
      abortMode <= 1'b0;
    end else begin
      case (state)
        S_ACC: if (inValid) begin
          if (inAbort || inEop) begin
            endPend   <= 1'b1;
            abortMode <= inAbort;
            fits      <= (padStart <= LEN_IDX);
            if (!inAbort && wIdx == LAST_IDX) begin
              state <= S_SEND;
              sIdx  <= '0;
              wIdx  <= '0;
            end else begin
              state <= S_PAD;
              wIdx  <= padStart;
            end
          end else if (wIdx == LAST_IDX) begin
            state <= S_SEND;
            sIdx  <= '0;
            wIdx  <= '0;
          end else begin
            wIdx <= wIdx + 1'b1;
          end
        end
        S_PAD: begin
          if (wIdx == LAST_IDX) begin
            state <= S_SEND;
            sIdx  <= '0;
            wIdx  <= '0;
          end else begin
            wIdx <= wIdx + 1'b1;
          end
        end
        S_SEND: if (outReady) begin
          if (sIdx == SEND_END) begin
            sIdx <= '0;
            if (endPend && !fits) begin
              fits  <= 1'b1;
              state <= S_PAD;
              wIdx  <= '0;
            end else begin
              state     <= S_ACC;
              endPend   <= 1'b0;
              abortMode <= 1'b0;
            end
          end else begin
            sIdx <= sIdx + 1'b1;
          end
        end
        default: state <= S_ACC;
      endcase
    end
  end

  AST_EOP_PAUSES_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && (inEop || inAbort)) |=> !inReady) else $error("end transfer did not pause input"); // R10
endmodule

// File: rtl/aal5SegData.sv
module aal5SegData
  import aal5SegPkg::*;
#(
  parameter int CONN_W = 4,
  parameter int VPI_W  = 8,
  parameter int VCI_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobes_t       stb,
  input  logic [31:0]       inData,
  input  logic [CONN_W-1:0] inConn,
  input  logic              inEop,
  input  logic [1:0]        inBytes,
  input  logic [7:0]        inUu,
  input  logic [7:0]        inCpi,
  input  logic              inClp,
  input  logic              inCi,
  input  logic              cfgWe,
  input  logic [CONN_W-1:0] cfgConn,
  input  logic [VPI_W-1:0]  cfgVpi,
  input  logic [VCI_W-1:0]  cfgVci,
  output logic [31:0]       outData
);
  localparam int NCONN = 1 << CONN_W;
  localparam int HDR_PAD = 32 - VPI_W - VCI_W - 4;

  logic [31:0]       cellBuf [CELL_WORDS];
  logic [31:0]       stCrc   [NCONN];
  logic [15:0]       stLen   [NCONN];
  logic [VPI_W-1:0]  vpiTab  [NCONN];
  logic [VCI_W-1:0]  vciTab  [NCONN];
  logic [31:0]       crcReg, hdrReg;
  logic [15:0]       lenReg;
  logic [CONN_W-1:0] connReg;
  logic [7:0]        uuReg, cpiReg;
  logic              clpReg, ciReg;

  logic [31:0]       baseCrc, crcNext, dataMask, dataMasked, padWord;
  logic [15:0]       baseLen, lenNext;
  logic [2:0]        byteCnt;
  logic [CONN_W-1:0] wrConn;
  logic [7:0]        uuNow, cpiNow;
  logic              clpNow, ciNow;

  assign wrConn  = stb.firstWord ? inConn : connReg;
  assign baseCrc = stb.firstWord ? stCrc[inConn] : crcReg;
  assign baseLen = stb.firstWord ? stLen[inConn] : lenReg;
  assign uuNow   = stb.latchAttr ? inUu  : uuReg;
  assign cpiNow  = stb.latchAttr ? inCpi : cpiReg;
  assign clpNow  = stb.latchAttr ? inClp : clpReg;
  assign ciNow   = stb.latchAttr ? inCi  : ciReg;

  always_comb begin
    dataMask = 32'hFFFFFFFF;
    byteCnt  = 3'd4;
    if (inEop) begin
      case (inBytes)
        2'd1: begin dataMask = 32'hFF000000; byteCnt = 3'd1; end
        2'd2: begin dataMask = 32'hFFFF0000; byteCnt = 3'd2; end
        2'd3: begin dataMask = 32'hFFFFFF00; byteCnt = 3'd3; end
        default: ;
      endcase
    end
  end

  assign dataMasked = inData & dataMask;

  always_comb begin
    case (stb.padSel)
      2'd1:    padWord = {uuReg, cpiReg, stb.zeroLen ? 16'h0000 : lenReg};
      2'd2:    padWord = ~crcReg;
      default: padWord = '0;
    endcase
  end

  always_comb begin
    crcNext = baseCrc;
    lenNext = baseLen;
    if (stb.takeWord) begin
      crcNext = crc32Word(baseCrc, dataMasked);
      lenNext = baseLen + 16'(byteCnt);
    end else if (stb.padWrite && stb.padSel != 2'd2) begin
      crcNext = crc32Word(crcReg, padWord);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CELL_WORDS; i++) cellBuf[i] <= '0;
      for (int c = 0; c < NCONN; c++) begin
        stCrc[c]  <= CRC_INIT;
        stLen[c]  <= '0;
        vpiTab[c] <= '0;
        vciTab[c] <= '0;
      end
      crcReg  <= CRC_INIT;
      lenReg  <= '0;
      hdrReg  <= '0;
      connReg <= '0;
      uuReg   <= '0;
      cpiReg  <= '0;
      clpReg  <= 1'b0;
      ciReg   <= 1'b0;
    end else begin
      crcReg <= crcNext;
      lenReg <= lenNext;
      if (stb.latchAttr) begin
        uuReg  <= inUu;
        cpiReg <= inCpi;
        clpReg <= inClp;
        ciReg  <= inCi;
      end
      if (stb.firstWord) connReg <= inConn;
      if (stb.takeWord) cellBuf[stb.wrIdx] <= dataMasked;
      if (stb.padWrite) cellBuf[stb.wrIdx] <= padWord;
      if (stb.saveState) begin
        stCrc[wrConn] <= crcNext;
        stLen[wrConn] <= lenNext;
      end
      if (stb.clearState) begin
        stCrc[wrConn] <= CRC_INIT;
        stLen[wrConn] <= '0;
      end
      if (stb.saveState || stb.clearState)
        hdrReg <= {{HDR_PAD{1'b0}}, vpiTab[wrConn], vciTab[wrConn], 1'b0, ciNow, stb.clearState, clpNow};
      if (cfgWe) begin
        vpiTab[cfgConn] <= cfgVpi;
        vciTab[cfgConn] <= cfgVci;
      end
    end
  end

  logic unusedAttr;
  assign unusedAttr = ^{uuNow, cpiNow};

  assign outData = (stb.rdIdx == '0) ? hdrReg : cellBuf[stb.rdIdx - 1'b1];

  AST_ABORT_ZERO_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.padWrite && stb.padSel == 2'd1 && stb.zeroLen) |=> (cellBuf[CELL_WORDS-2][15:0] == 16'h0000)) else $error("abort trailer length not zero"); // R9
endmodule

// File: rtl/aal5SegEngine.sv
module aal5SegEngine
  import aal5SegPkg::*;
#(
  parameter int CONN_W = 4,
  parameter int VPI_W  = 8,
  parameter int VCI_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [31:0]       inData,
  input  logic [CONN_W-1:0] inConn,
  input  logic              inEop,
  input  logic [1:0]        inBytes,
  input  logic              inAbort,
  input  logic [7:0]        inUu,
  input  logic [7:0]        inCpi,
  input  logic              inClp,
  input  logic              inCi,
  input  logic              cfgWe,
  input  logic [CONN_W-1:0] cfgConn,
  input  logic [VPI_W-1:0]  cfgVpi,
  input  logic [VCI_W-1:0]  cfgVci,
  output logic              outValid,
  input  logic              outReady,
  output logic [31:0]       outData,
  output logic              outSoc
);
  segStrobes_t stb;

  aal5SegCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inEop(inEop), .inAbort(inAbort),
    .outReady(outReady), .inReady(inReady), .outValid(outValid), .outSoc(outSoc), .stb(stb)
  );

  aal5SegData #(.CONN_W(CONN_W), .VPI_W(VPI_W), .VCI_W(VCI_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .inConn(inConn), .inEop(inEop),
    .inBytes(inBytes), .inUu(inUu), .inCpi(inCpi), .inClp(inClp), .inCi(inCi),
    .cfgWe(cfgWe), .cfgConn(cfgConn), .cfgVpi(cfgVpi), .cfgVci(cfgVci), .outData(outData)
  );

  // Output words counted modulo one cell, independent of the controller.
  logic [IDX_W-1:0] hsCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hsCnt <= '0;
    else if (outValid && outReady) hsCnt <= (hsCnt == IDX_W'(CELL_WORDS)) ? '0 : hsCnt + 1'b1;
  end

  AST_SOC_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outSoc == (hsCnt == '0))) else $error("start-of-cell out of place"); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outSoc))) else $error("stalled word changed"); // R10
  AST_NO_INPUT_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady) else $error("input accepted during send"); // R10
endmodule

// File: tb/sim_aal5SegEngine.sv
module sim_aal5SegEngine;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, inValid, inReady, inEop, inAbort, inClp, inCi, cfgWe, outValid, outReady, outSoc;
  logic [31:0] inData, outData;
  logic [3:0]  inConn, cfgConn;
  logic [1:0]  inBytes;
  logic [7:0]  inUu, inCpi, cfgVpi;
  logic [15:0] cfgVci;

  aal5SegEngine u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData), .inConn(inConn),
    .inEop(inEop), .inBytes(inBytes), .inAbort(inAbort), .inUu(inUu), .inCpi(inCpi), .inClp(inClp),
    .inCi(inCi), .cfgWe(cfgWe), .cfgConn(cfgConn), .cfgVpi(cfgVpi), .cfgVci(cfgVci),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outSoc(outSoc)
  );

  int nVec = 0;
  int nErr = 0;
  string curTag = "R2";
  logic [32:0] expQ[$];
  logic [31:0] mCrc [16];
  int          mLen [16];
  logic [7:0]  bVpi [16];
  logic [15:0] bVci [16];
  logic        bpMode = 1'b0;
  int          cyc = 0;
  logic        stallSeen = 1'b0;
  logic [32:0] stallWord;

  task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    nVec++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int i = 7; i >= 0; i--) r = (r[31] ^ b[i]) ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] byteAt(input int seed, input int i);
    return 8'(seed + i * 7 + 3);
  endfunction

  task automatic emitCell(input int conn, input logic [7:0] pay [48], input bit last);
    expQ.push_back({1'b1, 4'h0, bVpi[conn], bVci[conn], 1'b0, inCi, last, inClp});
    for (int w = 0; w < 12; w++)
      expQ.push_back({1'b0, pay[4*w], pay[4*w+1], pay[4*w+2], pay[4*w+3]});
  endtask

  task automatic finishCell(input int conn, input logic [7:0] cur [$], input bit isAbort);
    logic [7:0] all [$];
    logic [7:0] pay [48];
    logic [31:0] c;
    int lenF;
    all = cur;
    if (all.size() > 40) begin
      while (all.size() < 48) begin all.push_back(8'h00); mCrc[conn] = crcByte(mCrc[conn], 8'h00); end
      for (int i = 0; i < 48; i++) pay[i] = all[i];
      emitCell(conn, pay, 1'b0);
      all.delete();
    end
    while (all.size() < 40) begin all.push_back(8'h00); mCrc[conn] = crcByte(mCrc[conn], 8'h00); end
    lenF = isAbort ? 0 : mLen[conn];
    all.push_back(inUu); all.push_back(inCpi);
    all.push_back(8'(lenF >> 8)); all.push_back(8'(lenF));
    for (int i = 40; i < 44; i++) mCrc[conn] = crcByte(mCrc[conn], all[i]);
    c = ~mCrc[conn];
    all.push_back(c[31:24]); all.push_back(c[23:16]); all.push_back(c[15:8]); all.push_back(c[7:0]);
    for (int i = 0; i < 48; i++) pay[i] = all[i];
    emitCell(conn, pay, 1'b1);
    mCrc[conn] = 32'hFFFFFFFF;
    mLen[conn] = 0;
  endtask

  task automatic driveWord(input int conn, input logic [31:0] d, input bit eop, input logic [1:0] nb, input bit ab);
    bit ok;
    inValid = 1'b1; inConn = 4'(conn); inData = d; inEop = eop; inBytes = nb; inAbort = ab;
    forever begin
      ok = inReady;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0; inEop = 1'b0; inAbort = 1'b0;
  endtask

  task automatic setAttr(input logic [7:0] uu, input logic [7:0] cpi, input bit clp, input bit ci);
    inUu = uu; inCpi = cpi; inClp = clp; inCi = ci;
  endtask

  // Sends nBytes of a packet on conn; ends with an end flag or an abort transfer if asked.
  task automatic sendChunk(input int conn, input int nBytes, input bit eop, input bit abortTail, input int seed);
    logic [7:0] cur [$];
    logic [7:0] pay [48];
    int nWords;
    for (int i = 0; i < nBytes; i++) begin
      cur.push_back(byteAt(seed, i));
      mCrc[conn] = crcByte(mCrc[conn], byteAt(seed, i));
      mLen[conn]++;
      if (cur.size() == 48) begin
        for (int k = 0; k < 48; k++) pay[k] = cur[k];
        emitCell(conn, pay, 1'b0);
        cur.delete();
      end
    end
    if (eop || abortTail) finishCell(conn, cur, abortTail);
    nWords = (nBytes + 3) / 4;
    for (int w = 0; w < nWords; w++) begin
      logic [31:0] d;
      for (int b = 0; b < 4; b++)
        d[31-8*b -: 8] = (4*w + b < nBytes) ? byteAt(seed, 4*w + b) : 8'hA5;
      driveWord(conn, d, eop && (w == nWords - 1), 2'(nBytes % 4), 1'b0);
    end
    if (abortTail) driveWord(conn, 32'hDEADBEEF, 1'b0, 2'd0, 1'b1);
  endtask

  task automatic drain();
    int t = 0;
    while (expQ.size() != 0 && t < 20000) begin @(negedge clk); t++; end
    if (expQ.size() != 0) begin
      nErr++;
      $display("FAIL %s actual=%0d words left expected=0", curTag, expQ.size());
    end
  endtask

  // Output monitor and backpressure pattern.
  always @(negedge clk) begin
    logic rdy;
    logic [32:0] e;
    cyc++;
    rdy = bpMode ? ((cyc % 3) != 0) : 1'b1;
    if (rstN) begin
      if (stallSeen)
        check(outValid && ({outSoc, outData} == stallWord), "R10", {outSoc, outData}, stallWord);
      stallSeen = outValid && !rdy;
      stallWord = {outSoc, outData};
      if (outValid && rdy) begin
        if (expQ.size() == 0) check(1'b0, curTag, {outSoc, outData}, 33'h0);
        else begin
          e = expQ.pop_front();
          check({outSoc, outData} == e, e[32] ? {curTag, "/R2/R3/R8"} : {curTag, "/R7"}, {outSoc, outData}, e);
        end
      end
    end
    outReady = rdy;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inData = '0; inConn = '0; inEop = 1'b0; inBytes = '0; inAbort = 1'b0;
    setAttr(8'h00, 8'h00, 1'b0, 1'b0);
    cfgWe = 1'b0; cfgConn = '0; cfgVpi = '0; cfgVci = '0; outReady = 1'b1;
    for (int c = 0; c < 16; c++) begin mCrc[c] = 32'hFFFFFFFF; mLen[c] = 0; bVpi[c] = '0; bVci[c] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1", {32'h0, outValid}, 33'h0);
    check(inReady == 1'b1, "R1", {32'h0, inReady}, 33'h1);

    // R1: a packet before any table write uses zero identifiers and a fresh state
    curTag = "R1";
    setAttr(8'h11, 8'h00, 1'b0, 1'b0);
    sendChunk(0, 5, 1'b1, 1'b0, 9);
    drain();

    // R3: load the identifier table
    for (int c = 0; c < 16; c++) begin
      bVpi[c] = 8'(c * 5 + 1);
      bVci[c] = 16'(16'h0100 + c * 37);
      cfgWe = 1'b1; cfgConn = 4'(c); cfgVpi = bVpi[c]; cfgVci = bVci[c];
      @(negedge clk);
    end
    cfgWe = 1'b0;

    // R5/R6/R7/R8: sweep every length 1..100 across all connections
    curTag = "R5_R6";
    for (int n = 1; n <= 100; n++) begin
      bpMode = (n > 50);
      setAttr(8'(n), 8'(n * 3), n[0], n[1]);
      sendChunk(n % 16, n, 1'b1, 1'b0, n);
    end
    drain();

    // R4: interleave whole cells of three connections
    curTag = "R4";
    for (int k = 0; k < 3; k++) begin
      setAttr(8'h31, 8'h01, 1'b1, 1'b0); sendChunk(3, 48, 1'b0, 1'b0, 100 + k);
      setAttr(8'h72, 8'h02, 1'b0, 1'b1); sendChunk(7, 96, 1'b0, 1'b0, 120 + k);
      setAttr(8'hC3, 8'h03, 1'b1, 1'b1); sendChunk(12, 48, 1'b0, 1'b0, 140 + k);
    end
    setAttr(8'h72, 8'h02, 1'b0, 1'b1); sendChunk(7, 45, 1'b1, 1'b0, 77);
    setAttr(8'h31, 8'h01, 1'b1, 1'b0); sendChunk(3, 13, 1'b1, 1'b0, 33);
    setAttr(8'hC3, 8'h03, 1'b1, 1'b1); sendChunk(12, 40, 1'b1, 1'b0, 55);
    drain();

    // R9: abort at a cell boundary, mid-cell, mid-cell past 40 bytes, and on an idle connection
    curTag = "R9";
    bpMode = 1'b1;
    setAttr(8'h5A, 8'h00, 1'b0, 1'b0);
    sendChunk(5, 96, 1'b0, 1'b1, 200);
    sendChunk(6, 20, 1'b0, 1'b1, 210);
    sendChunk(6, 44, 1'b0, 1'b1, 220);
    sendChunk(9, 0, 1'b0, 1'b1, 0);
    drain();

    // R11: connections start fresh after an abort and after a normal end
    curTag = "R11";
    setAttr(8'hA0, 8'h07, 1'b1, 1'b0);
    sendChunk(5, 30, 1'b1, 1'b0, 230);
    sendChunk(6, 41, 1'b1, 1'b0, 240);
    drain();

    // R5: maximum packet length
    curTag = "R5_max";
    bpMode = 1'b0;
    setAttr(8'hEE, 8'h00, 1'b0, 1'b1);
    sendChunk(1, 32768, 1'b1, 1'b0, 17);
    drain();

    @(negedge clk);
    check(inReady == 1'b1, "R10", {32'h0, inReady}, 33'h1);
    check(outValid == 1'b0, "R10", {32'h0, outValid}, 33'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end
endmodule